// File: doc/BRIEF.md
# Word-Granular DMA into a Banked Sample Store

This block copies a host-requested number of 16-bit words from a 16 KB source buffer into one 4 KB bank of a sample store. The host supplies two address registers and a word count, and pulses `start`. The source register holds a byte address. The destination register holds an address in 4-byte units, so it is shifted left by two before use. Both addresses are forced to word alignment. Each one then wraps on its own: the source wraps inside the 16 KB buffer and the destination wraps inside the 4 KB bank.

When a start is accepted, the block returns the updated register values for the host to store back, all in one strobe cycle. The source value advances by twice the count. The destination value advances by half the count, because of its coarser unit. The block then moves the words one at a time: it fetches from the source port and writes to the sample-store port. The two bytes of each word are passed through unchanged, since the store is only ever read bytewise. A stall input holds off the write side while another user owns the sample store, and no data is lost during a stall. `busy` covers the whole transfer, and `done` pulses once at the end.

Top module: `wdma_bank_copy`

## Requirements
- R1: The first source byte index is `src_reg[13:0]` with bit 0 cleared; source register bits above 13 are ignored.
- R2: The first destination byte index is `(dst_reg << 2)` truncated to 12 bits with bit 0 cleared.
- R3: After each word is written, the source index advances by 2 and wraps from 0x3FFE to 0, and the destination index advances by 2 and wraps from 0xFFE to 0. Exactly N words are written.
- R4: On the cycle after an accepted start, `reg_wb` is high for one cycle. In that cycle `src_reg_upd` equals `src_reg + 2*N` and `dst_reg_upd` equals `dst_reg + (N >> 1)`, both taken modulo 2^16 from the values present at start.
- R5: The write address is `{bank, dst_index}` (bank in bits 15:12). The bank is sampled at start, so later changes on `bank_sel` do not affect a running transfer.
- R6: Each stored word equals the source word read from the matching source index, with its bit order unchanged.
- R7: `busy` is high from the cycle after an accepted start with N>0 until the last word is written. `done` is high for exactly one cycle, in the first cycle in which `busy` is low again.
- R8: While `stall` is high, `ram_wr_en` is low. The pending word and its address are held, so the sequence of writes matches the sequence without a stall.
- R9: A `start` while `busy` is high is ignored: it produces no write-back strobe and no extra writes.
- R10: A start with N=0 performs no writes, keeps `busy` low, and pulses `done` and `reg_wb` in the next cycle with the register values unchanged.
- R11: During reset and after it, `busy`, `done`, `reg_wb`, `src_rd_en` and `ram_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| word_cnt | input | 16 | Number of words N |
| src_reg | input | 16 | Source address register (bytes) |
| dst_reg | input | 16 | Destination address register (4-byte units) |
| bank_sel | input | 4 | Active sample-store bank |
| stall | input | 1 | Hold off sample-store writes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| reg_wb | output | 1 | Write-back strobe for the updated registers |
| src_reg_upd | output | 16 | Updated source register |
| dst_reg_upd | output | 16 | Updated destination register |
| src_rd_en | output | 1 | Source read request |
| src_rd_addr | output | 14 | Source byte index (data returns one cycle later) |
| src_rd_data | input | 16 | Source read data |
| ram_wr_en | output | 1 | Sample-store write strobe |
| ram_wr_addr | output | 16 | Sample-store byte address |
| ram_wr_data | output | 16 | Word to store |

## Verification
The first transfer starts both indices at zero with no stall, which shows the basic fetch/store order and the write-back sums. Later transfers start with unaligned register values and with high bits that must be masked off. Some start near the top of the buffer or the bank, so that the source and destination wraps happen at different words and an error in either one is visible on its own. A pseudo-random stall is applied across long, odd-length transfers, to catch lost or repeated words. A second start issued mid-transfer, and a start with a zero count, separate the idle-only acceptance rule from the normal completion path.

// File: rtl/wdma_pkg.sv
package wdma_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_STORE = 2'd2
   } wdma_state_t;
endpackage

// File: rtl/wdma_idx_ring.sv
// Word-aligned byte index that wraps at 2**AW; loaded from a scaled register.
module wdma_idx_ring #(
   parameter int REG_W = 16,
   parameter int AW    = 14,
   parameter int SHIFT = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [REG_W-1:0] reg_in,
   output logic [AW-1:0]    idx
);
   localparam int EXT_W = REG_W + SHIFT;

   logic [EXT_W-1:0] scaled;
   logic [AW-1:0]    load_v;
   logic [AW-1:0]    idx_q;

   assign scaled = EXT_W'(reg_in) << SHIFT;

   generate
      if (AW < 2) begin : g_bad_aw
         $error("wdma_idx_ring: AW must be at least 2");
      end
      if (EXT_W >= AW) begin : g_trunc
         assign load_v = {scaled[AW-1:1], 1'b0};
      end else begin : g_extend
         assign load_v = {{(AW-EXT_W){1'b0}}, scaled[EXT_W-1:1], 1'b0};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    idx_q <= '0;
      else if (load) idx_q <= load_v;
      else if (step) idx_q <= idx_q + AW'(2);
   end

   assign idx = idx_q;
endmodule

// File: rtl/wdma_ctrl.sv
// Transfer sequencer: fetch one word, store it (honouring stall), repeat N times.
module wdma_ctrl
   import wdma_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] cnt,
   input  logic             stall,
   output wdma_state_t      state,
   output logic             accept,
   output logic             advance,
   output logic             done
);
   wdma_state_t      state_q, state_d;
   logic [CNT_W-1:0] left_q;
   logic             last_word;
   logic             zero_cnt;
   logic             done_q;

   assign accept    = (state_q == ST_IDLE) && start;
   assign advance   = (state_q == ST_STORE) && !stall;
   assign last_word = (left_q == CNT_W'(1));
   assign zero_cnt  = (cnt == '0);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (accept && !zero_cnt) state_d = ST_FETCH;
         ST_FETCH: state_d = ST_STORE;
         ST_STORE: if (advance) state_d = last_word ? ST_IDLE : ST_FETCH;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         left_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= (accept && zero_cnt) || (advance && last_word);
         if (accept)       left_q <= cnt;
         else if (advance) left_q <= left_q - CNT_W'(1);
      end
   end

   assign state = state_q;
   assign done  = done_q;
endmodule

// File: rtl/wdma_bank_copy.sv
module wdma_bank_copy
   import wdma_pkg::*;
#(
   parameter int REG_W   = 16,
   parameter int CNT_W   = 16,
   parameter int DATA_W  = 16,
   parameter int SRC_AW  = 14,
   parameter int BANK_AW = 12,
   parameter int BANK_W  = 4,
   parameter int DST_SHIFT = 2,
   localparam int RAM_AW = BANK_W + BANK_AW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [CNT_W-1:0]   word_cnt,
   input  logic [REG_W-1:0]   src_reg,
   input  logic [REG_W-1:0]   dst_reg,
   input  logic [BANK_W-1:0]  bank_sel,
   input  logic               stall,
   output logic               busy,
   output logic               done,
   output logic               reg_wb,
   output logic [REG_W-1:0]   src_reg_upd,
   output logic [REG_W-1:0]   dst_reg_upd,
   output logic               src_rd_en,
   output logic [SRC_AW-1:0]  src_rd_addr,
   input  logic [DATA_W-1:0]  src_rd_data,
   output logic               ram_wr_en,
   output logic [RAM_AW-1:0]  ram_wr_addr,
   output logic [DATA_W-1:0]  ram_wr_data
);
   generate
      if (DATA_W != 16) begin : g_bad_data
         $error("wdma_bank_copy: index step of 2 bytes assumes 16-bit words");
      end
      if (SRC_AW > REG_W) begin : g_bad_src
         $error("wdma_bank_copy: source register narrower than source index");
      end
   endgenerate

   wdma_state_t       state;
   logic              accept, advance;
   logic [SRC_AW-1:0] src_idx;
   logic [BANK_AW-1:0] dst_idx;
   logic [BANK_W-1:0] bank_q;
   logic              held_q;
   logic [DATA_W-1:0] word_q;
   logic [DATA_W-1:0] cur_word;
   logic              wb_q;
   logic [REG_W-1:0]  src_upd_q, dst_upd_q;
   logic [REG_W-1:0]  cnt_ext;

   wdma_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .cnt    (word_cnt),
      .stall  (stall),
      .state  (state),
      .accept (accept),
      .advance(advance),
      .done   (done)
   );

   wdma_idx_ring #(.REG_W(REG_W), .AW(SRC_AW), .SHIFT(0)) u_src_idx (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .step  (advance),
      .reg_in(src_reg),
      .idx   (src_idx)
   );

   wdma_idx_ring #(.REG_W(REG_W), .AW(BANK_AW), .SHIFT(DST_SHIFT)) u_dst_idx (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .step  (advance),
      .reg_in(dst_reg),
      .idx   (dst_idx)
   );

   assign cnt_ext  = REG_W'(word_cnt);
   assign cur_word = held_q ? word_q : src_rd_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q    <= '0;
         held_q    <= 1'b0;
         word_q    <= '0;
         wb_q      <= 1'b0;
         src_upd_q <= '0;
         dst_upd_q <= '0;
      end else begin
         wb_q <= accept;
         if (accept) begin
            bank_q    <= bank_sel;
            src_upd_q <= src_reg + (cnt_ext << 1);
            dst_upd_q <= dst_reg + REG_W'(word_cnt >> 1);
         end
         if (state == ST_FETCH) begin
            held_q <= 1'b0;
         end else if (state == ST_STORE && stall) begin
            held_q <= 1'b1;
            word_q <= cur_word;
         end
      end
   end

   assign busy        = (state != ST_IDLE);
   assign reg_wb      = wb_q;
   assign src_reg_upd = src_upd_q;
   assign dst_reg_upd = dst_upd_q;
   assign src_rd_en   = (state == ST_FETCH);
   assign src_rd_addr = src_idx;
   assign ram_wr_en   = advance;
   assign ram_wr_addr = {bank_q, dst_idx};
   assign ram_wr_data = cur_word;
endmodule

// File: rtl/wdma_bank_copy_chk.sv
module wdma_bank_copy_chk #(
   parameter int RAM_AW = 16,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              stall,
   input logic              busy,
   input logic              done,
   input logic              reg_wb,
   input logic              src_rd_en,
   input logic              ram_wr_en,
   input logic [RAM_AW-1:0] ram_wr_addr,
   input logic [DATA_W-1:0] ram_wr_data
);
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r8_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> !ram_wr_en);

   // R8: a stalled store keeps its address and word for the retry
   a_r8_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy && stall && !src_rd_en) |-> ($stable(ram_wr_addr) && $stable(ram_wr_data)));

   a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy) |=> !reg_wb);

   a_r4_wb_origin: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wb |-> ($past(start) && !$past(busy)));

   a_r6_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ram_wr_en |-> (busy && !src_rd_en));
endmodule

bind wdma_bank_copy wdma_bank_copy_chk #(.RAM_AW(RAM_AW), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .stall      (stall),
   .busy       (busy),
   .done       (done),
   .reg_wb     (reg_wb),
   .src_rd_en  (src_rd_en),
   .ram_wr_en  (ram_wr_en),
   .ram_wr_addr(ram_wr_addr),
   .ram_wr_data(ram_wr_data)
);

// File: tb/wdma_bank_copy_test.sv
`timescale 1ns/1ps
module wdma_bank_copy_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] word_cnt = '0;
   logic [15:0] src_reg = '0;
   logic [15:0] dst_reg = '0;
   logic [3:0]  bank_sel = '0;
   logic        stall = 1'b0;
   logic        busy, done, reg_wb;
   logic [15:0] src_reg_upd, dst_reg_upd;
   logic        src_rd_en;
   logic [13:0] src_rd_addr;
   logic [15:0] src_rd_data = '0;
   logic        ram_wr_en;
   logic [15:0] ram_wr_addr, ram_wr_data;

   int checks = 0;
   int fails  = 0;
   int wb_cnt = 0;
   bit stall_en = 1'b0;
   logic [31:0] exp_q[$];

   always #2.5 clk = ~clk;

   wdma_bank_copy uut (
      .clk(clk), .rst_n(rst_n), .start(start), .word_cnt(word_cnt),
      .src_reg(src_reg), .dst_reg(dst_reg), .bank_sel(bank_sel), .stall(stall),
      .busy(busy), .done(done), .reg_wb(reg_wb),
      .src_reg_upd(src_reg_upd), .dst_reg_upd(dst_reg_upd),
      .src_rd_en(src_rd_en), .src_rd_addr(src_rd_addr), .src_rd_data(src_rd_data),
      .ram_wr_en(ram_wr_en), .ram_wr_addr(ram_wr_addr), .ram_wr_data(ram_wr_data)
   );

   function automatic logic [15:0] src_word(input logic [13:0] a);
      return (16'(a) * 16'h9E37) ^ 16'h1234;
   endfunction

   // source buffer model: one cycle read latency
   always @(posedge clk) if (src_rd_en) src_rd_data <= src_word(src_rd_addr);

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // monitor: scoreboard pop on every store
   initial forever begin
      @(negedge clk);
      if (reg_wb) wb_cnt++;
      if (ram_wr_en) begin
         if (exp_q.size() == 0) check(1'b0, "R3 extra write", {ram_wr_addr, ram_wr_data}, 32'h0);
         else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            check(ram_wr_addr == e[31:16], "R1/R2/R3/R5 write address", 32'(ram_wr_addr), 32'(e[31:16]));
            check(ram_wr_data == e[15:0], "R6/R8 stored word", 32'(ram_wr_data), 32'(e[15:0]));
         end
      end
   end

   // pseudo-random stall source
   initial begin
      logic [7:0] lf;
      lf = 8'hA7;
      forever begin
         @(posedge clk); #1;
         lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
         stall = stall_en & lf[0] & (lf[1] | lf[2]);
      end
   end

   task automatic run_xfer(input logic [15:0] s_in, input logic [15:0] d_in, input logic [3:0] bk,
                           input logic [15:0] n, input bit stl, input bit intrude);
      logic [13:0] s;
      logic [11:0] d;
      int wb0, cyc;
      bit busy_ok;
      s = s_in[13:0] & 14'h3FFE;                // R1
      d = 12'(d_in << 2) & 12'hFFE;             // R2
      for (int i = 0; i < int'(n); i++) begin
         exp_q.push_back({bk, d, src_word(s)});
         s = s + 14'd2;                         // R3 wraps at 16 KB
         d = d + 12'd2;                         // R3 wraps at 4 KB
      end
      wb0 = wb_cnt;
      stall_en = stl;
      @(posedge clk); #1;
      start = 1'b1; word_cnt = n; src_reg = s_in; dst_reg = d_in; bank_sel = bk;
      @(posedge clk); #1;
      start = 1'b0; src_reg = 16'hFFFF; dst_reg = 16'hFFFF; bank_sel = ~bk;   // R5 latched
      @(negedge clk);
      check(reg_wb == 1'b1, "R4 wb strobe", 32'(reg_wb), 32'd1);
      check(src_reg_upd == 16'(s_in + (n << 1)), "R4 src update", 32'(src_reg_upd), 32'(16'(s_in + (n << 1))));
      check(dst_reg_upd == 16'(d_in + (n >> 1)), "R4 dst update", 32'(dst_reg_upd), 32'(16'(d_in + (n >> 1))));
      check(busy == (n != 0), "R7/R10 busy after start", 32'(busy), 32'(n != 0));
      if (n == 0) check(done == 1'b1, "R10 done on zero count", 32'(done), 32'd1);
      if (intrude) begin
         @(posedge clk); #1;
         start = 1'b1; word_cnt = 16'd7; src_reg = 16'h0100; dst_reg = 16'h0040;  // R9
         @(posedge clk); #1;
         start = 1'b0;
         @(negedge clk);
      end
      cyc = 0; busy_ok = 1'b1;
      while (!done && cyc < 5000) begin
         if (!busy) busy_ok = 1'b0;
         @(negedge clk); cyc++;
      end
      check(busy_ok, "R7 busy held until finish", 32'(busy_ok), 32'd1);
      check(done == 1'b1 && busy == 1'b0, "R7 done with busy low", {30'd0, done, busy}, 32'h2);
      @(negedge clk);
      check(done == 1'b0, "R7 done one cycle", 32'(done), 32'd0);
      check(exp_q.size() == 0, "R3/R10 word count", 32'(exp_q.size()), 32'd0);
      check(wb_cnt == wb0 + 1, "R9 single write-back", 32'(wb_cnt - wb0), 32'd1);
      stall_en = 1'b0;
      @(posedge clk); #1;
   endtask

   initial begin
      #1000;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !done && !reg_wb && !src_rd_en && !ram_wr_en, "R11 in reset",
            {27'd0, busy, done, reg_wb, src_rd_en, ram_wr_en}, 32'd0);
      @(posedge clk); #1; rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!busy && !done && !reg_wb && !src_rd_en && !ram_wr_en, "R11 after reset",
            {27'd0, busy, done, reg_wb, src_rd_en, ram_wr_en}, 32'd0);
      run_xfer(16'h0000, 16'h0000, 4'h0, 16'd4, 1'b0, 1'b0);   // basic
      run_xfer(16'h7FFB, 16'h03FE, 4'h5, 16'd6, 1'b0, 1'b0);   // R1 masking, R3 both wraps
      run_xfer(16'h1235, 16'h4001, 4'hF, 16'd5, 1'b1, 1'b0);   // R2 truncation, R8 stall
      run_xfer(16'h2222, 16'h0333, 4'h3, 16'd0, 1'b0, 1'b0);   // R10 zero count
      run_xfer(16'h0FF0, 16'h0010, 4'h9, 16'd3, 1'b0, 1'b1);   // R9 start while busy
      run_xfer(16'h3FF8, 16'hFFFE, 4'hA, 16'd9, 1'b1, 1'b0);   // R4 wrap of register sums, R8
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule